// File: doc/BRIEF.md
# Eight-Bit Execute ALU with Carry and Zero Flags

This block is the combinational execute stage of a small controller that uses 18-bit instruction words and an 8-bit data path. It receives the whole instruction word, the destination register value, the source register value and the present carry and zero flags. In the same cycle it returns the 8-bit result, a write-back strobe for the destination register, and the flag values to be latched. The surrounding core owns the register file, the flag registers, memory, I/O and program flow. It applies the write-back strobe and latches the returned flags at its own clock edge.

The block covers addition and subtraction, each with and without carry. It also covers AND, OR, XOR, move, compare, test, four rotates and the four instructions that set or clear a single flag. Every operation decides for itself which flags it touches. Any flag it does not touch is returned unchanged. Immediate forms take their second operand from the low byte of the instruction word in place of the source register value. Every opcode outside this group leaves the registers and flags untouched.

The block holds no state. Its decoder translates the opcode and sub-field into a small control word, and each datapath unit is selected by that word.

Top module: `alu8_core`

## Requirements
- R1: The opcode is `instr[17:13]`. The destination and source register fields (`instr[12:8]`, `instr[7:3]`) have no effect, since their values arrive on `opa`/`opb`. For opcodes 00000 to 10011, an odd opcode (bit 13 set) takes its second operand from `instr[7:0]` and ignores `opb`. An even opcode uses `opb`.
- R2: Opcodes 00100 (add), 00101 (add immediate), 00110 (add with carry) and 00111 (add immediate with carry) write `opa + B (+ carry_in for 0011x)` modulo 256. `carry_out` is the ninth sum bit.
- R3: Opcodes 00000 (sub), 00001 (sub immediate), 00010 (sub with borrow) and 00011 (sub immediate with borrow) write `opa - B (- carry_in for 0001x)` modulo 256. `carry_out` is 1 exactly when the true difference is negative.
- R4: Opcodes 01000 and 01001 (move) write B. Opcodes 01010/01011 write `opa & B`, 01100/01101 write `opa | B`, and 01110/01111 write `opa ^ B`. All of these keep `carry_in`.
- R5: Opcodes 10000/10001 (compare) set both flags exactly as a subtract would. Opcodes 10010/10011 (test) set zero from `opa & B` and keep carry. Neither writes back. `result` shows the discarded value.
- R6: For every operation that updates zero, `zero_out` is 1 exactly when the 8-bit result is 0x00.
- R7: Opcode 10100 rotates `opb` (never `opa`). With `instr[2:0]`=000 it rotates right (`{b[0],b[7:1]}`), and with 001 it rotates left (`{b[6:0],b[7]}`). Both write back and keep carry.
- R8: Opcode 10100 with `instr[2:0]`=010 gives `{carry_in,b[7:1]}` and sets carry to `b[0]`. With 011 it gives `{b[6:0],carry_in}` and sets carry to `b[7]`. Both write back.
- R9: Opcode 10110 with `instr[2:0]` = 000/001/010/011 clears carry, sets carry, clears zero or sets zero respectively. The other flag is kept, there is no write-back, and `result` is 0x00.
- R10: Any other opcode, and opcodes 10100 or 10110 with `instr[2]`=1, give `wr_en`=0, `result`=0x00 and both flags passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 18 | Instruction word being executed |
| opa | input | 8 | Destination register value |
| opb | input | 8 | Source register value |
| carry_in | input | 1 | Current carry flag |
| zero_in | input | 1 | Current zero flag |
| result | output | 8 | Computed value |
| wr_en | output | 1 | Write result to destination register |
| carry_out | output | 1 | Next carry flag |
| zero_out | output | 1 | Next zero flag |

## Verification
A vector table drives each opcode with operands chosen to expose one behaviour at a time:
- Sums that do and do not overflow separate the carry-out from the result bits.
- Subtractions with the subtrahend larger, equal and smaller tell borrow apart from zero.
- Inputs with carry set show which operations fold carry in and which ignore it.
- Immediates paired with a conflicting `opb` reveal the wrong operand source.
- Rotate sources with only bit 0 or only bit 7 set reveal direction and which bit leaves through carry.
- Illegal sub-fields and opcodes are applied with flags that differ from any value an operation would produce, so any unintended update shows.

A sweep of add and subtract over spread operand pairs then checks the carry rule against integer arithmetic, and a directed case fills the register fields with ones.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W  = 8;
    localparam int INSTR_W = 18;
    localparam int OPC_W   = 5;
    localparam int OPC_LSB = INSTR_W - OPC_W;

    typedef enum logic [2:0] {
        U_NONE,
        U_ADD,
        U_SUB,
        U_LOGIC,
        U_MOVE,
        U_ROT,
        U_FLAG
    } unit_e;

    typedef enum logic [1:0] {
        LG_PASS = 2'b00,
        LG_AND  = 2'b01,
        LG_OR   = 2'b10,
        LG_XOR  = 2'b11
    } logic_e;

    typedef struct packed {
        unit_e      unit;
        logic       use_imm;
        logic       use_cin;
        logic       wb;
        logic       upd_c;
        logic       upd_z;
        logic_e     lsel;
        logic [1:0] sub_sel;
    } ctrl_t;

    localparam logic [OPC_W-1:0] OPC_ROTATE = 5'b10100;
    localparam logic [OPC_W-1:0] OPC_FLAGOP = 5'b10110;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
    import alu8_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output ctrl_t              ctrl
);

    logic [OPC_W-1:0] opc;
    logic [2:0]       low;

    assign opc = instr[INSTR_W-1:OPC_LSB];
    assign low = instr[2:0];

    always_comb begin
        ctrl         = '0;
        ctrl.unit    = U_NONE;
        ctrl.lsel    = LG_PASS;
        unique casez (opc)
            5'b000??: begin
                ctrl.unit    = U_SUB;
                ctrl.use_imm = opc[0];
                ctrl.use_cin = opc[1];
                ctrl.wb      = 1'b1;
                ctrl.upd_c   = 1'b1;
                ctrl.upd_z   = 1'b1;
            end
            5'b001??: begin
                ctrl.unit    = U_ADD;
                ctrl.use_imm = opc[0];
                ctrl.use_cin = opc[1];
                ctrl.wb      = 1'b1;
                ctrl.upd_c   = 1'b1;
                ctrl.upd_z   = 1'b1;
            end
            5'b01???: begin
                ctrl.unit    = (opc[2:1] == 2'b00) ? U_MOVE : U_LOGIC;
                ctrl.lsel    = logic_e'(opc[2:1]);
                ctrl.use_imm = opc[0];
                ctrl.wb      = 1'b1;
                ctrl.upd_z   = 1'b1;
            end
            5'b100??: begin
                ctrl.use_imm = opc[0];
                ctrl.upd_z   = 1'b1;
                if (opc[1]) begin
                    ctrl.unit = U_LOGIC;
                    ctrl.lsel = LG_AND;
                end else begin
                    ctrl.unit  = U_SUB;
                    ctrl.upd_c = 1'b1;
                end
            end
            OPC_ROTATE: begin
                if (!low[2]) begin
                    ctrl.unit    = U_ROT;
                    ctrl.sub_sel = low[1:0];
                    ctrl.wb      = 1'b1;
                    ctrl.upd_z   = 1'b1;
                    ctrl.upd_c   = low[1];
                end
            end
            OPC_FLAGOP: begin
                if (!low[2]) begin
                    ctrl.unit    = U_FLAG;
                    ctrl.sub_sel = low[1:0];
                    ctrl.upd_c   = ~low[1];
                    ctrl.upd_z   = low[1];
                end
            end
            default: ctrl.unit = U_NONE;
        endcase
    end

endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout
);

    localparam int EXT_W = W + 1;

    logic [EXT_W-1:0] wide;

    always_comb begin
        if (sub) begin
            wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
        end else begin
            wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        end
    end

    assign sum  = wide[W-1:0];
    assign cout = wide[EXT_W-1];

endmodule

// File: rtl/alu8_rotate.sv
module alu8_rotate #(
    parameter int W = 8
) (
    input  logic [W-1:0] src,
    input  logic         cin,
    input  logic [1:0]   mode,
    output logic [W-1:0] res,
    output logic         cout
);

    logic fill_r;
    logic fill_l;

    assign fill_r = mode[1] ? cin : src[0];
    assign fill_l = mode[1] ? cin : src[W-1];

    always_comb begin
        if (mode[0]) begin
            res  = {src[W-2:0], fill_l};
            cout = src[W-1];
        end else begin
            res  = {fill_r, src[W-1:1]};
            cout = src[0];
        end
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  opa,
    input  logic [DATA_W-1:0]  opb,
    input  logic               carry_in,
    input  logic               zero_in,
    output logic [DATA_W-1:0]  result,
    output logic               wr_en,
    output logic               carry_out,
    output logic               zero_out
);

    ctrl_t             ctrl;
    logic [DATA_W-1:0] b_sel;
    logic [DATA_W-1:0] as_sum;
    logic              as_cout;
    logic [DATA_W-1:0] rot_res;
    logic              rot_cout;
    logic [DATA_W-1:0] lg_res;
    logic [DATA_W-1:0] value;
    logic              c_calc;

    alu8_decode i_dec (
        .instr (instr),
        .ctrl  (ctrl)
    );

    assign b_sel = ctrl.use_imm ? instr[DATA_W-1:0] : opb;

    alu8_addsub #(.W(DATA_W)) i_addsub (
        .a    (opa),
        .b    (b_sel),
        .cin  (ctrl.use_cin & carry_in),
        .sub  (ctrl.unit == U_SUB),
        .sum  (as_sum),
        .cout (as_cout)
    );

    alu8_rotate #(.W(DATA_W)) i_rot (
        .src  (opb),
        .cin  (carry_in),
        .mode (ctrl.sub_sel),
        .res  (rot_res),
        .cout (rot_cout)
    );

    always_comb begin
        unique case (ctrl.lsel)
            LG_AND:  lg_res = opa & b_sel;
            LG_OR:   lg_res = opa | b_sel;
            LG_XOR:  lg_res = opa ^ b_sel;
            default: lg_res = b_sel;
        endcase
    end

    always_comb begin
        value  = '0;
        c_calc = carry_in;
        unique case (ctrl.unit)
            U_ADD, U_SUB: begin
                value  = as_sum;
                c_calc = as_cout;
            end
            U_LOGIC, U_MOVE: value = lg_res;
            U_ROT: begin
                value  = rot_res;
                c_calc = rot_cout;
            end
            U_FLAG:  c_calc = ctrl.sub_sel[0];
            default: value  = '0;
        endcase
    end

    assign result    = value;
    assign wr_en     = ctrl.wb;
    assign carry_out = ctrl.upd_c ? c_calc : carry_in;
    assign zero_out  = !ctrl.upd_z ? zero_in
                     : (ctrl.unit == U_FLAG) ? ctrl.sub_sel[0]
                     : (value == '0);

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
(
    input logic [INSTR_W-1:0] instr,
    input logic [DATA_W-1:0]  opb,
    input logic               carry_in,
    input logic               zero_in,
    input logic [DATA_W-1:0]  result,
    input logic               wr_en,
    input logic               carry_out,
    input logic               zero_out
);

    logic [OPC_W-1:0] opc;
    logic [2:0]       low;
    logic             is_cmp_test;
    logic             is_flagop;

    assign opc         = instr[INSTR_W-1:OPC_LSB];
    assign low         = instr[2:0];
    assign is_cmp_test = (opc[4:2] == 3'b100);
    assign is_flagop   = (opc == OPC_FLAGOP) && !low[2];

    always_comb begin
        if (!$isunknown({instr, opb, carry_in, zero_in})) begin
            // R5
            cmp_no_wb_chk: assert (!(is_cmp_test && wr_en))
                else $error("compare/test asserted write-back");
            // R4
            logic_keeps_c_chk: assert (!(opc[4:3] == 2'b01 && carry_out != carry_in))
                else $error("logic/move changed carry");
            // R7
            plain_rot_c_chk: assert (!(opc == OPC_ROTATE && low[2:1] == 2'b00
                                       && carry_out != carry_in))
                else $error("plain rotate changed carry");
            // R8
            rorc_c_chk: assert (!(opc == OPC_ROTATE && low == 3'b010
                                  && carry_out != opb[0]))
                else $error("rotate-right-through-carry lost bit 0");
            // R6
            zero_match_chk: assert (!(wr_en && (zero_out != (result == '0))))
                else $error("zero flag does not match result");
            // R9
            flagop_no_wb_chk: assert (!(is_flagop && (wr_en || result != '0)))
                else $error("flag op wrote back");
            // R10
            idle_pass_chk: assert (wr_en || is_cmp_test || is_flagop
                                   || (carry_out == carry_in && zero_out == zero_in
                                       && result == '0))
                else $error("unrecognised opcode had an effect");
        end
    end

endmodule

bind alu8_core alu8_core_chk i_chk (
    .instr     (instr),
    .opb       (opb),
    .carry_in  (carry_in),
    .zero_in   (zero_in),
    .result    (result),
    .wr_en     (wr_en),
    .carry_out (carry_out),
    .zero_out  (zero_out)
);

// File: tb/test_alu8_core.sv
`timescale 1ns/1ps
module test_alu8_core;

    localparam int VW = 55;
    localparam int NV = 30;
    localparam int WATCHDOG = 20000;

    // fields: instr[54:37] a[36:29] b[28:21] cin[20] zin[19] res[18:11] wr[10] c[9] z[8] req[7:0]
    localparam logic [VW-1:0] VEC [NV] = '{
        {5'b00100, 5'd0, 8'h00, 8'hF0, 8'h20, 1'b1, 1'b0, 8'h10, 1'b1, 1'b1, 1'b0, 8'd2},  // R2 add ignores carry_in, carries out
        {5'b00110, 5'd0, 8'h00, 8'hFF, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'd2},  // R2 addc wraps to zero
        {5'b00101, 5'd0, 8'h05, 8'h10, 8'hAA, 1'b0, 1'b1, 8'h15, 1'b1, 1'b0, 1'b0, 8'd1},  // R1 immediate replaces opb
        {5'b00111, 5'd0, 8'hFE, 8'h01, 8'h77, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'd2},  // R2 addic
        {5'b00000, 5'd0, 8'h00, 8'h05, 8'h07, 1'b0, 1'b1, 8'hFE, 1'b1, 1'b1, 1'b0, 8'd3},  // R3 sub negative
        {5'b00010, 5'd0, 8'h00, 8'h07, 8'h06, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'd3},  // R3 subc exact zero
        {5'b00001, 5'd0, 8'h03, 8'h03, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'd3},  // R3 subi ignores carry_in
        {5'b00011, 5'd0, 8'h00, 8'h00, 8'h55, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b0, 8'd3},  // R3 subic borrow
        {5'b01001, 5'd0, 8'h3C, 8'h11, 8'h99, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b1, 1'b0, 8'd4},  // R4 movi
        {5'b01000, 5'd0, 8'h00, 8'h55, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'd6},  // R6 mov zero value
        {5'b01010, 5'd0, 8'h00, 8'hF0, 8'h0F, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'd4},  // R4 and
        {5'b01101, 5'd0, 8'h81, 8'h02, 8'h00, 1'b0, 1'b1, 8'h83, 1'b1, 1'b0, 1'b0, 8'd4},  // R4 ori
        {5'b01110, 5'd0, 8'h00, 8'hA5, 8'hA5, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'd6},  // R6 xor self
        {5'b10000, 5'd0, 8'h00, 8'h10, 8'h20, 1'b0, 1'b1, 8'hF0, 1'b0, 1'b1, 1'b0, 8'd5},  // R5 cmp less
        {5'b10001, 5'd0, 8'h42, 8'h42, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'd5},  // R5 cmpi equal
        {5'b10010, 5'd0, 8'h00, 8'h0C, 8'h03, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'd5},  // R5 test disjoint
        {5'b10011, 5'd0, 8'h80, 8'h81, 8'h00, 1'b0, 1'b1, 8'h80, 1'b0, 1'b0, 1'b0, 8'd5},  // R5 testi overlap
        {5'b10100, 5'd0, 8'h00, 8'hFF, 8'h01, 1'b0, 1'b1, 8'h80, 1'b1, 1'b0, 1'b0, 8'd7},  // R7 ror
        {5'b10100, 5'd0, 8'h01, 8'h00, 8'h80, 1'b1, 1'b0, 8'h01, 1'b1, 1'b1, 1'b0, 8'd7},  // R7 rol
        {5'b10100, 5'd0, 8'h02, 8'h00, 8'h01, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'd8},  // R8 rorc out bit0
        {5'b10100, 5'd0, 8'h03, 8'h00, 8'h80, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'd8},  // R8 rolc out bit7
        {5'b10100, 5'd0, 8'h02, 8'h00, 8'h02, 1'b1, 1'b1, 8'h81, 1'b1, 1'b0, 1'b0, 8'd8},  // R8 rorc carry in
        {5'b10110, 5'd0, 8'h00, 8'h12, 8'h34, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'd9},  // R9 clrc
        {5'b10110, 5'd0, 8'h01, 8'h12, 8'h34, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'd9},  // R9 setc
        {5'b10110, 5'd0, 8'h02, 8'h12, 8'h34, 1'b1, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 8'd9},  // R9 clrz
        {5'b10110, 5'd0, 8'h03, 8'h12, 8'h34, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'd9},  // R9 setz
        {5'b11000, 5'd0, 8'h00, 8'hFF, 8'hFF, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'd10}, // R10 unknown opcode
        {5'b10100, 5'd0, 8'h04, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'd10}, // R10 rotate bit2 set
        {5'b10110, 5'd0, 8'h07, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'd10}, // R10 flag op bit2 set
        {5'b10101, 5'd0, 8'h00, 8'h01, 8'h01, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'd10}  // R10 gap opcode
    };

    logic        clk = 1'b0;
    logic [17:0] instr;
    logic [7:0]  opa;
    logic [7:0]  opb;
    logic        carry_in;
    logic        zero_in;
    logic [7:0]  result;
    logic        wr_en;
    logic        carry_out;
    logic        zero_out;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    alu8_core i_alu8_core (
        .instr     (instr),
        .opa       (opa),
        .opb       (opb),
        .carry_in  (carry_in),
        .zero_in   (zero_in),
        .result    (result),
        .wr_en     (wr_en),
        .carry_out (carry_out),
        .zero_out  (zero_out)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: cycles %0d expected below %0d", cycles, WATCHDOG);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    task automatic apply(input logic [17:0] i, input logic [7:0] a, input logic [7:0] b,
                         input logic ci, input logic zi);
        @(posedge clk);
        #1;
        instr    = i;
        opa      = a;
        opb      = b;
        carry_in = ci;
        zero_in  = zi;
        @(negedge clk);
    endtask

    task automatic expect_out(input int req, input logic [7:0] r, input logic w,
                              input logic c, input logic z);
        n_vec = n_vec + 1;
        if (result !== r || wr_en !== w || carry_out !== c || zero_out !== z) begin
            n_fail = n_fail + 1;
            $display("FAIL R%0d instr=%05h: got res=%02h wr=%b c=%b z=%b expected res=%02h wr=%b c=%b z=%b",
                     req, instr, result, wr_en, carry_out, zero_out, r, w, c, z);
        end
    endtask

    initial begin
        instr    = '0;
        opa      = '0;
        opb      = '0;
        carry_in = 1'b0;
        zero_in  = 1'b0;

        // idle state before any instruction: sub of 0-0 (R3)
        apply(18'h00000, 8'h00, 8'h00, 1'b0, 1'b0);
        expect_out(3, 8'h00, 1'b1, 1'b0, 1'b1);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][54:37], VEC[i][36:29], VEC[i][28:21], VEC[i][20], VEC[i][19]);
            expect_out(int'(VEC[i][7:0]), VEC[i][18:11], VEC[i][10], VEC[i][9], VEC[i][8]);
        end

        // R1: register fields all ones do not disturb an add
        apply({5'b00100, 5'b11111, 5'b11111, 3'b000}, 8'h01, 8'h02, 1'b1, 1'b1);
        expect_out(1, 8'h03, 1'b1, 1'b0, 1'b0);

        // R2 / R3 sweep against integer arithmetic
        for (int a = 0; a < 256; a += 17) begin
            for (int b = 0; b < 256; b += 23) begin
                int s;
                int d;
                s = a + b;
                d = a - b;
                apply({5'b00100, 13'd0}, 8'(a), 8'(b), 1'b0, 1'b0);
                expect_out(2, 8'(s), 1'b1, s > 255, (s % 256) == 0);
                apply({5'b00000, 13'd0}, 8'(a), 8'(b), 1'b0, 1'b0);
                expect_out(3, 8'(d), 1'b1, d < 0, d == 0);
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule